// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Gate

This block decides the cycle in which an in-order pipeline takes an external interrupt. A hardware request arrives either on a legacy request pin, which can carry any vector, or from a local interrupt controller. The controller path is only allowed to deliver vectors 16 and above. The block holds the request as pending and waits for a retirement boundary. When the interrupt-enable flag is set, it accepts the request and raises a one-cycle accept pulse. The pulse comes with the vector and with the return pointer that the pipeline must save.

Software interrupt instructions do not go through the pending holder. They are presented with the retiring instruction and taken at that same boundary. The enable flag does not gate them, and they win over a hardware request that is waiting at the same boundary.

A boundary can also be the end of one iteration of a repeat-prefixed instruction that has more iterations to run. In that case the saved pointer is the address of that instruction, so that the next iteration runs when the handler returns.

Top module: `irq_accept_gate`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `accept_o`, `accept_sw_o`, `illegal_vec_o`, `accept_vec_o` and `ret_ptr_o` are all zero, and no hardware request is pending.
- R2: A hardware request held high at a clock edge becomes pending at that edge. It stays pending until it is accepted or `hw_req_i` is low at an edge. A withdrawn request is never accepted. After an acceptance, the same request is not taken again until `hw_req_i` has gone low.
- R3: `accept_o` is high only in the cycle that follows a cycle with `retire_i` high, and it lasts one cycle per boundary. In cycles without an acceptance, `accept_vec_o`, `ret_ptr_o`, `illegal_vec_o` and `accept_sw_o` read zero.
- R4: While `int_en_i` is low at a boundary, a pending hardware request is not accepted on either path. It stays pending and is accepted at the first boundary where `int_en_i` is high.
- R5: `sw_req_i` high together with `retire_i` is accepted at that boundary whatever the value of `int_en_i`. The result is `accept_sw_o`=1 and `accept_vec_o`=`sw_vec_i`.
- R6: When a software request and a pending hardware request meet at the same boundary, only the software request is accepted. The hardware request stays pending for a later boundary.
- R7: A request from the local controller path (`hw_src_i`=1) with a vector from 0 to 15 is accepted with `illegal_vec_o`=1. Vectors from 16 to 255 on that path give `illegal_vec_o`=0.
- R8: A request on the legacy pin path (`hw_src_i`=0) is accepted with any vector from 0 to 255, with `illegal_vec_o`=0. The accepted vector is the one present when the request became pending.
- R9: For a hardware acceptance, `ret_ptr_o` is `retire_pc_i` when `rep_more_i` is high and `retire_npc_i` otherwise. For a software acceptance, it is always `retire_npc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req_i | input | 1 | Hardware interrupt request level |
| hw_src_i | input | 1 | Request path: 0 legacy pin, 1 local controller |
| hw_vec_i | input | 8 | Hardware request vector |
| int_en_i | input | 1 | Interrupt-enable flag |
| sw_req_i | input | 1 | Retiring instruction is a software interrupt |
| sw_vec_i | input | 8 | Software interrupt vector |
| retire_i | input | 1 | Instruction boundary strobe from retirement |
| retire_pc_i | input | 32 | Address of the retiring instruction |
| retire_npc_i | input | 32 | Address of the next instruction in program order |
| rep_more_i | input | 1 | Retiring repeat iteration has further iterations |
| accept_o | output | 1 | One-cycle acceptance pulse |
| accept_sw_o | output | 1 | Accepted request came from software |
| accept_vec_o | output | 8 | Accepted vector |
| illegal_vec_o | output | 1 | Accepted vector is illegal for the local controller path |
| ret_ptr_o | output | 32 | Return pointer to save |

## Verification
A hardware request needs one edge to become pending. It can therefore be accepted at the earliest at the edge that closes the next boundary cycle. All acceptance results, including the return pointer, appear in the cycle after the boundary cycle. A software request shows up in the cycle right after its own boundary. The bench drives inputs on the falling edge and advances its own expectation model at each rising edge. It compares every output on the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    parameter int VEC_W         = 8;
    parameter int PC_W          = 32;
    parameter int LOCAL_MIN_VEC = 16;

    typedef enum logic [1:0] {
        HOLD_IDLE   = 2'd0,
        HOLD_PEND   = 2'd1,
        HOLD_SERVED = 2'd2
    } hold_state_e;

    typedef enum logic {
        SRC_PIN   = 1'b0,
        SRC_LOCAL = 1'b1
    } irq_src_e;

    typedef struct packed {
        logic             valid;
        irq_src_e         src;
        logic [VEC_W-1:0] vec;
    } hw_pend_t;

    typedef struct packed {
        logic             accept;
        logic             is_sw;
        logic             illegal;
        logic [VEC_W-1:0] vec;
        logic [PC_W-1:0]  ret_ptr;
    } accept_t;

    function automatic logic vec_illegal(irq_src_e src, logic [VEC_W-1:0] v);
        return (src == SRC_LOCAL) && (int'(v) < LOCAL_MIN_VEC);
    endfunction

endpackage

// File: rtl/irq_pend_hold.sv
module irq_pend_hold
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_req_i,
    input  logic             hw_src_i,
    input  logic [VEC_W-1:0] hw_vec_i,
    input  logic             take_i,
    output hw_pend_t         pend_o
);

    hold_state_e      state_q, state_d;
    irq_src_e         src_q;
    logic [VEC_W-1:0] vec_q;
    logic             capture;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        case (state_q)
            HOLD_IDLE: begin
                if (hw_req_i) begin
                    state_d = HOLD_PEND;
                    capture = 1'b1;
                end
            end
            HOLD_PEND: begin
                if (!hw_req_i)   state_d = HOLD_IDLE;
                else if (take_i) state_d = HOLD_SERVED;
            end
            HOLD_SERVED: begin
                if (!hw_req_i) state_d = HOLD_IDLE;
            end
            default: state_d = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HOLD_IDLE;
            src_q   <= SRC_PIN;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                src_q <= irq_src_e'(hw_src_i);
                vec_q <= hw_vec_i;
            end
        end
    end

    assign pend_o.valid = (state_q == HOLD_PEND);
    assign pend_o.src   = src_q;
    assign pend_o.vec   = vec_q;

    // R2
    withdraw_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !hw_req_i |=> !pend_o.valid);

    // R2
    taken_not_repeated_chk: assert property (@(posedge clk) disable iff (rst)
        (take_i && pend_o.valid) |=> !pend_o.valid);

endmodule

// File: rtl/irq_ret_select.sv
module irq_ret_select
    import irq_gate_pkg::*;
(
    input  logic            is_sw_i,
    input  logic            rep_more_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] npc_i,
    output logic [PC_W-1:0] ret_ptr_o
);

    always_comb begin
        if (!is_sw_i && rep_more_i) ret_ptr_o = pc_i;
        else                        ret_ptr_o = npc_i;
    end

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_req_i,
    input  logic             hw_src_i,
    input  logic [VEC_W-1:0] hw_vec_i,
    input  logic             int_en_i,
    input  logic             sw_req_i,
    input  logic [VEC_W-1:0] sw_vec_i,
    input  logic             retire_i,
    input  logic [PC_W-1:0]  retire_pc_i,
    input  logic [PC_W-1:0]  retire_npc_i,
    input  logic             rep_more_i,
    output logic             accept_o,
    output logic             accept_sw_o,
    output logic [VEC_W-1:0] accept_vec_o,
    output logic             illegal_vec_o,
    output logic [PC_W-1:0]  ret_ptr_o
);

    hw_pend_t        pend;
    accept_t         acc_d, acc_q;
    logic            take_sw, take_hw;
    logic [PC_W-1:0] ret_sel;

    irq_pend_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .hw_req_i (hw_req_i),
        .hw_src_i (hw_src_i),
        .hw_vec_i (hw_vec_i),
        .take_i   (take_hw),
        .pend_o   (pend)
    );

    // software first; hardware only when enabled and nothing from software
    assign take_sw = retire_i && sw_req_i;
    assign take_hw = retire_i && !sw_req_i && pend.valid && int_en_i;

    irq_ret_select u_ret (
        .is_sw_i    (take_sw),
        .rep_more_i (rep_more_i),
        .pc_i       (retire_pc_i),
        .npc_i      (retire_npc_i),
        .ret_ptr_o  (ret_sel)
    );

    always_comb begin
        acc_d = '0;
        if (take_sw) begin
            acc_d.accept  = 1'b1;
            acc_d.is_sw   = 1'b1;
            acc_d.vec     = sw_vec_i;
            acc_d.ret_ptr = ret_sel;
        end else if (take_hw) begin
            acc_d.accept  = 1'b1;
            acc_d.illegal = vec_illegal(pend.src, pend.vec);
            acc_d.vec     = pend.vec;
            acc_d.ret_ptr = ret_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign accept_o      = acc_q.accept;
    assign accept_sw_o   = acc_q.is_sw;
    assign accept_vec_o  = acc_q.vec;
    assign illegal_vec_o = acc_q.illegal;
    assign ret_ptr_o     = acc_q.ret_ptr;

    // R3
    boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> $past(retire_i));

    // R4
    masked_hw_chk: assert property (@(posedge clk) disable iff (rst)
        (accept_o && !accept_sw_o) |-> $past(int_en_i));

    // R5
    sw_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        (retire_i && sw_req_i) |=> (accept_o && accept_sw_o));

    // R6
    hw_waits_for_sw_chk: assert property (@(posedge clk) disable iff (rst)
        (retire_i && sw_req_i && pend.valid && hw_req_i) |=> pend.valid);

    // R7
    illegal_only_hw_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_vec_o |-> (accept_o && !accept_sw_o && (int'(accept_vec_o) < LOCAL_MIN_VEC)));

endmodule

// File: tb/test_irq_accept_gate.sv
module test_irq_accept_gate;

    logic        clk = 1'b0;
    logic        rst;
    logic        hw_req, hw_src, int_en, sw_req, retire, rep_more;
    logic [7:0]  hw_vec, sw_vec;
    logic [31:0] rpc, rnpc;
    logic        acc, acc_sw, ill;
    logic [7:0]  acc_vec;
    logic [31:0] rptr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // expectation model state
    int          m_st;   // 0 idle, 1 pending, 2 served
    logic        m_src;
    logic [7:0]  m_vec;
    logic        e_acc, e_sw, e_ill;
    logic [7:0]  e_vec;
    logic [31:0] e_ptr;

    always #2 clk = ~clk;

    irq_accept_gate i_irq_accept_gate (
        .clk(clk), .rst(rst),
        .hw_req_i(hw_req), .hw_src_i(hw_src), .hw_vec_i(hw_vec),
        .int_en_i(int_en), .sw_req_i(sw_req), .sw_vec_i(sw_vec),
        .retire_i(retire), .retire_pc_i(rpc), .retire_npc_i(rnpc),
        .rep_more_i(rep_more),
        .accept_o(acc), .accept_sw_o(acc_sw), .accept_vec_o(acc_vec),
        .illegal_vec_o(ill), .ret_ptr_o(rptr)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic illegal_ref(logic src, logic [7:0] v);
        return src && (v < 8'd16);
    endfunction

    // advance the model at the rising edge, compare at the falling edge
    task automatic tick();
        logic tsw, thw;
        @(posedge clk);
        cyc++;
        if (rst) begin
            m_st = 0; e_acc = 0; e_sw = 0; e_ill = 0; e_vec = 0; e_ptr = 0;
        end else begin
            tsw = retire && sw_req;
            thw = retire && !sw_req && (m_st == 1) && int_en;
            e_acc = tsw || thw; e_sw = tsw; e_ill = 0; e_vec = 0; e_ptr = 0;
            if (tsw) begin
                e_vec = sw_vec; e_ptr = rnpc;
            end else if (thw) begin
                e_vec = m_vec; e_ill = illegal_ref(m_src, m_vec);
                e_ptr = rep_more ? rpc : rnpc;
            end
            case (m_st)
                0: if (hw_req) begin m_st = 1; m_src = hw_src; m_vec = hw_vec; end
                1: if (!hw_req) m_st = 0; else if (thw) m_st = 2;
                default: if (!hw_req) m_st = 0;
            endcase
        end
        @(negedge clk);
        check(acc === e_acc, "R3 accept", 32'(acc), 32'(e_acc));
        check(acc_sw === e_sw, "R6 source", 32'(acc_sw), 32'(e_sw));
        check(acc_vec === e_vec, e_sw ? "R5 vector" : "R8 vector", 32'(acc_vec), 32'(e_vec));
        check(ill === e_ill, "R7 illegal", 32'(ill), 32'(e_ill));
        check(rptr === e_ptr, "R9 return", rptr, e_ptr);
    endtask

    task automatic idle_inputs();
        retire = 0; sw_req = 0; rep_more = 0;
    endtask

    task automatic boundary(input logic sw, input logic [7:0] sv, input logic rep);
        retire = 1; sw_req = sw; sw_vec = sv; rep_more = rep;
        rpc = rpc + 32'h10; rnpc = rpc + 32'h4;
        tick();
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        rst = 1; hw_req = 0; hw_src = 0; hw_vec = 0; int_en = 0;
        sw_vec = 0; rpc = 32'h1000; rnpc = 32'h1004;
        idle_inputs();
        tick(); tick();
        rst = 0;
        // R1: reset state
        check(acc === 0 && acc_sw === 0 && ill === 0, "R1 flags", 32'(acc), 0);
        check(acc_vec === 0 && rptr === 0, "R1 data", rptr, 0);

        // R8: legacy pin, low vector
        int_en = 1; hw_req = 1; hw_src = 0; hw_vec = 8'd5;
        tick();
        boundary(0, 0, 0);
        check(acc === 1 && acc_vec === 8'd5 && ill === 0, "R8 legacy low vec", 32'(acc_vec), 5);
        hw_req = 0; tick();

        // R2: withdrawn before a boundary is never taken
        hw_req = 1; hw_vec = 8'd77; tick();
        hw_req = 0; tick();
        boundary(0, 0, 0);
        check(acc === 0, "R2 withdrawn", 32'(acc), 0);

        // R4: masked, then enabled
        int_en = 0; hw_req = 1; hw_src = 1; hw_vec = 8'd40; tick();
        boundary(0, 0, 0);
        check(acc === 0, "R4 masked local", 32'(acc), 0);
        hw_src = 0;
        boundary(0, 0, 0);
        check(acc === 0, "R4 masked again", 32'(acc), 0);
        int_en = 1;
        boundary(0, 0, 0);
        check(acc === 1 && acc_vec === 8'd40 && ill === 0, "R4 taken when enabled", 32'(acc_vec), 40);
        // R2: held request not taken twice
        boundary(0, 0, 0);
        check(acc === 0, "R2 no repeat", 32'(acc), 0);
        hw_req = 0; tick();

        // R5: software with enable clear
        int_en = 0;
        boundary(1, 8'd35, 0);
        check(acc === 1 && acc_sw === 1 && acc_vec === 8'd35, "R5 sw unmasked", 32'(acc_vec), 35);

        // R6: software beats hardware at the same boundary
        int_en = 1; hw_req = 1; hw_src = 0; hw_vec = 8'd99; tick();
        boundary(1, 8'd2, 0);
        check(acc_sw === 1 && acc_vec === 8'd2, "R6 sw first", 32'(acc_vec), 2);
        boundary(0, 0, 0);
        check(acc === 1 && acc_sw === 0 && acc_vec === 8'd99, "R6 hw after", 32'(acc_vec), 99);
        hw_req = 0; tick();

        // R7: local path low vector is illegal; R9 repeat boundary
        hw_req = 1; hw_src = 1; hw_vec = 8'd3; tick();
        boundary(0, 0, 1);
        check(ill === 1 && acc === 1, "R7 illegal low", 32'(ill), 1);
        check(rptr === rpc, "R9 repeat ptr", rptr, rpc);
        hw_req = 0; tick();
        hw_req = 1; hw_vec = 8'd16; tick();
        boundary(0, 0, 0);
        check(ill === 0 && acc_vec === 8'd16, "R7 legal 16", 32'(ill), 0);
        check(rptr === rnpc, "R9 normal ptr", rptr, rnpc);
        hw_req = 0; tick();
        // R9: software ignores the repeat flag
        boundary(1, 8'd200, 1);
        check(rptr === rnpc, "R9 sw ptr", rptr, rnpc);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if (hw_req) begin
                if ($urandom % 6 == 0) hw_req = 0;
            end else if ($urandom % 4 == 0) begin
                hw_req = 1; hw_src = 1'($urandom); hw_vec = 8'($urandom);
            end
            if ($urandom % 8 == 0) int_en = ~int_en;
            retire   = ($urandom % 3 == 0);
            sw_req   = retire && ($urandom % 5 == 0);
            sw_vec   = 8'($urandom);
            rep_more = ($urandom % 4 == 0);
            rpc      = $urandom;
            rnpc     = rpc + 32'(1 + $urandom % 15);
            tick();
        end
        idle_inputs(); hw_req = 0;
        tick(); tick();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule